// File: doc/BRIEF.md
# Up/Down Binary Counter with Cascade Strobe

This block is a small binary counter that steps up or down by one on each rising clock edge while its active-low enable is asserted. The direction comes from a single select line. An active-low preset input forces the parallel data word onto the count outputs immediately, whatever the clock is doing, and holds it there for as long as the input stays low. A synchronous active-low reset clears the count on a clock edge when no preset is active.

Two flags support building wider counters. The terminal flag goes high when the count sits at the last value in the current direction: all ones when counting up, zero when counting down. The cascade strobe is an active-low pulse. It can fall only during the low half of the clock, while the stage is enabled and at its terminal value. The next stage can use it as a clock, or as a carry/borrow enable.

Top module: `updn_ripple_counter`

## Requirements
- R1: While `load_n` is 0, `count` equals `preset` at once and follows any change of `preset` with no clock edge; this overrides reset, enable, direction and clock.
- R2: With `load_n`=1, `rst_n`=1 and `en_n`=0, a rising `clk` edge with `dir_down`=0 raises `count` by one.
- R3: With `load_n`=1, `rst_n`=1 and `en_n`=0, a rising `clk` edge with `dir_down`=1 lowers `count` by one.
- R4: Counting wraps modulo 2^WIDTH: up from all ones gives 0, and down from 0 gives all ones.
- R5: With `load_n`=1, `rst_n`=1 and `en_n`=1, `count` keeps its value across clock edges for any `dir_down`.
- R6: `tc` is 1 exactly when `dir_down`=0 and `count` is all ones, or `dir_down`=1 and `count` is 0. It changes with `dir_down` without a clock edge and does not depend on `en_n`.
- R7: `rc_n` is 0 only while `en_n`=0, `tc`=1 and `clk`=0, and it is 1 whenever `clk` is 1.
- R8: While `en_n`=1, `rc_n` stays 1 in both clock phases.
- R9: A rising `clk` edge with `rst_n`=0 and `load_n`=1 sets `count` to 0.
- R10: After `load_n` returns to 1, the count steps from the loaded value on the next enabled rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active; its low phase gates the cascade strobe |
| rst_n | input | 1 | Synchronous reset, active low, clears the count |
| load_n | input | 1 | Asynchronous preset, active low |
| en_n | input | 1 | Count enable, active low |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| preset | input | WIDTH | Parallel data to preset |
| count | output | WIDTH | Current count |
| tc | output | 1 | Terminal flag, active high |
| rc_n | output | 1 | Cascade strobe, active low |

## Verification
The bound checker checks these on every cycle: single steps up and down with wrap, holding while disabled, clearing on reset, tracking of the preset data during a load, the terminal decode, and the strobe level in each clock phase. Some behaviours can only be shown by the bench's scenarios. These are the live following of `preset` between clock edges, the terminal flag flipping when `dir_down` changes between edges at 0 and at all ones, and counting restarting from a loaded value. The bench does an exhaustive sweep of every start value in both directions, compared against an arithmetic model.

// File: rtl/updn_ripple_counter_pkg.sv
// Package: shared types for the up/down counter.
// Assumes: nothing; holds only the operating-mode encoding.
package updn_ripple_counter_pkg;

    // Operating mode selected for the next rising clock edge.
    typedef enum logic [2:0] {
        MODE_HOLD  = 3'd0,
        MODE_UP    = 3'd1,
        MODE_DOWN  = 3'd2,
        MODE_CLEAR = 3'd3,
        MODE_LOAD  = 3'd4
    } udc_mode_e;

endpackage

// File: rtl/udc_mode_decode.sv
// Module: udc_mode_decode
// Picks the action for the next clock edge from the control inputs.
// Priority: preset, then reset, then enable, then direction.
// Assumes: all controls are active-low apart from dir_down.
module udc_mode_decode
    import updn_ripple_counter_pkg::*;
(
    input  logic      load_n,
    input  logic      rst_n,
    input  logic      en_n,
    input  logic      dir_down,
    output udc_mode_e mode
);

    // Decode the mode by fixed priority.
    always_comb begin
        if (!load_n)      mode = MODE_LOAD;
        else if (!rst_n)  mode = MODE_CLEAR;
        else if (en_n)    mode = MODE_HOLD;
        else if (dir_down) mode = MODE_DOWN;
        else              mode = MODE_UP;
    end

endmodule

// File: rtl/udc_state_reg.sv
// Module: udc_state_reg
// Holds the count. The register is set asynchronously while load_n is low.
// Otherwise it takes the next value for the decoded mode on each rising edge.
// A bypass mux puts the live preset word on the output during a load.
// Assumes: preset is stable from the last clock edge inside a load until
// load_n rises, so the register keeps the final loaded word.
module udc_state_reg
    import updn_ripple_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             load_n,
    input  udc_mode_e        mode,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] value
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_nxt;

    // Next count for the decoded mode; wraps modulo 2^WIDTH.
    always_comb begin
        unique case (mode)
            MODE_UP:    cnt_nxt = cnt_q + ONE;
            MODE_DOWN:  cnt_nxt = cnt_q - ONE;
            MODE_CLEAR: cnt_nxt = '0;
            MODE_LOAD:  cnt_nxt = preset;
            default:    cnt_nxt = cnt_q;
        endcase
    end

    // Count register with an asynchronous preset.
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) cnt_q <= preset;
        else         cnt_q <= cnt_nxt;
    end

    // Make the preset word visible at once while the load is held.
    assign value = load_n ? cnt_q : preset;

endmodule

// File: rtl/udc_terminal_detect.sv
// Module: udc_terminal_detect
// Flags the last value in the current direction: all ones going up,
// all zeros going down. The enable plays no part.
// Assumes: value is the visible count, so a preset is decoded at once.
module udc_terminal_detect #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] value,
    input  logic             dir_down,
    output logic             term
);

    logic [WIDTH:0] ones_chain;
    logic [WIDTH:0] zero_chain;

    assign ones_chain[0] = 1'b1;
    assign zero_chain[0] = 1'b1;

    // Build one AND chain per direction, a bit at a time.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign ones_chain[i+1] = ones_chain[i] &  value[i];
        assign zero_chain[i+1] = zero_chain[i] & ~value[i];
    end

    // Choose the detector for the current direction.
    assign term = dir_down ? zero_chain[WIDTH] : ones_chain[WIDTH];

endmodule

// File: rtl/udc_ripple_gate.sv
// Module: udc_ripple_gate
// Makes the active-low cascade strobe. It is low only in the clock's low
// phase, while enabled and at the terminal value.
// Assumes: clk is a clean clock; the strobe is a level-gated copy of it.
module udc_ripple_gate (
    input  logic clk,
    input  logic en_n,
    input  logic term,
    output logic strobe_n
);

    // Gate the low clock phase with enable and terminal.
    assign strobe_n = ~(~en_n & term & ~clk);

endmodule

// File: rtl/updn_ripple_counter.sv
// Module: updn_ripple_counter (top)
// Up/down binary counter with asynchronous preset, synchronous clear,
// a terminal flag and a clock-phase-gated cascade strobe.
// Assumes: preset has priority over reset, and reset over counting.
module updn_ripple_counter
    import updn_ripple_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             en_n,
    input  logic             dir_down,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count,
    output logic             tc,
    output logic             rc_n
);

    udc_mode_e mode;

    // Pick this edge's action.
    udc_mode_decode u_mode (
        .load_n   (load_n),
        .rst_n    (rst_n),
        .en_n     (en_n),
        .dir_down (dir_down),
        .mode     (mode)
    );

    // Count storage and preset bypass.
    udc_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk    (clk),
        .load_n (load_n),
        .mode   (mode),
        .preset (preset),
        .value  (count)
    );

    // Terminal flag for the current direction.
    udc_terminal_detect #(.WIDTH(WIDTH)) u_term (
        .value    (count),
        .dir_down (dir_down),
        .term     (tc)
    );

    // Cascade strobe.
    udc_ripple_gate u_rc (
        .clk      (clk),
        .en_n     (en_n),
        .term     (tc),
        .strobe_n (rc_n)
    );

endmodule

// File: rtl/updn_ripple_counter_chk.sv
// Module: updn_ripple_counter_chk
// Port-level checker bound to the counter top.
// Assumes: in use, preset pulses on load_n span at least one rising edge.
module updn_ripple_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic             en_n,
    input logic             dir_down,
    input logic [WIDTH-1:0] preset,
    input logic [WIDTH-1:0] count,
    input logic             tc,
    input logic             rc_n
);

    localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    // R2 and R4: an enabled up step adds one, wrapping.
    p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_n) && load_n && !$past(en_n) && !$past(dir_down))
        |-> count == $past(count) + ONE);

    // R3 and R4: an enabled down step subtracts one, wrapping.
    p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_n) && load_n && !$past(en_n) && $past(dir_down))
        |-> count == $past(count) - ONE);

    // R5: the count holds while disabled.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_n) && load_n && $past(en_n))
        |-> $stable(count));

    // R9: the count clears after a reset edge.
    p_sync_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && $past(load_n) && load_n) |-> count == '0);

    // R1: the preset word shows while loading.
    p_load_track_r1: assert property (@(negedge clk) disable iff (!rst_n)
        !load_n |-> count == preset);

    // R6: the terminal decode at the ports.
    p_term_decode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tc == (dir_down ? (count == '0) : (count == ALL1)));

    // R7: the strobe is low in the low phase when enabled at the terminal value.
    p_strobe_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && tc) |-> !rc_n);

    // R7: the strobe is high during the high phase.
    p_strobe_high_r7: assert property (@(negedge clk) disable iff (!rst_n)
        rc_n);

    // R8: a disabled stage gives no strobe.
    p_strobe_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |-> rc_n);

endmodule

bind updn_ripple_counter updn_ripple_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .en_n     (en_n),
    .dir_down (dir_down),
    .preset   (preset),
    .count    (count),
    .tc       (tc),
    .rc_n     (rc_n)
);

// File: tb/updn_ripple_counter_tb.sv
// Bench: exhaustive start-value sweep in both directions against an
// arithmetic model, plus preset, reset and direction-flip scenarios.
module updn_ripple_counter_tb;

    localparam int W = 4;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         en_n = 1'b1;
    logic         dir_down = 1'b0;
    logic [W-1:0] preset = '0;
    logic [W-1:0] count;
    logic         tc;
    logic         rc_n;

    int           n_chk = 0;
    int           n_bad = 0;
    int           exp_q = 0;

    updn_ripple_counter #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_n(en_n),
        .dir_down(dir_down), .preset(preset), .count(count), .tc(tc), .rc_n(rc_n)
    );

    always #5 clk = ~clk;

    // Compare one value and record a miscompare.
    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int shown();
        return load_n ? exp_q : int'(preset);
    endfunction

    function automatic int exp_tc();
        return dir_down ? int'(shown() == 0) : int'(shown() == MAXV);
    endfunction

    // One cycle: high-phase and low-phase checks, then the model steps at the edge.
    task automatic run_cycle(input string req);
        #2;
        check({req, " count"}, int'(count), shown());
        check("R6 tc", int'(tc), exp_tc());
        check("R7 rc_n high phase", int'(rc_n), 1);
        @(negedge clk); #2;
        check(en_n ? "R8 rc_n quiet" : "R7 rc_n low phase",
              int'(rc_n), (!en_n && exp_tc() == 1) ? 0 : 1);
        @(posedge clk);
        if (!load_n)      exp_q = int'(preset);
        else if (!rst_n)  exp_q = 0;
        else if (!en_n)   exp_q = dir_down ? (exp_q + MAXV) % (MAXV + 1) : (exp_q + 1) % (MAXV + 1);
        #1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(100000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        exp_q = 0;
        check("R9 reset count", int'(count), 0);
        rst_n = 1'b1;

        // Exhaustive sweep: each start value, both directions, with wrap and holds.
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s <= MAXV; s++) begin
                dir_down = d[0]; load_n = 1'b0; en_n = 1'b1; preset = W'(s);
                run_cycle("R1 load");
                load_n = 1'b1;
                for (int k = 0; k < MAXV + 3; k++) begin
                    en_n = (k % 5 == 3);
                    run_cycle(en_n ? "R5 hold" : (d == 0 ? "R2 R4 up" : "R3 R4 down"));
                end
            end
        end

        // R6: a direction flip at all ones and at zero, with no edge in between.
        for (int v = 0; v < 2; v++) begin
            load_n = 1'b0; en_n = 1'b1; preset = v ? '0 : W'(MAXV);
            run_cycle("R1 load");
            load_n = 1'b1; dir_down = 1'b0; #1;
            check("R6 tc up flip", int'(tc), v ? 0 : 1);
            dir_down = 1'b1; #1;
            check("R6 tc down flip", int'(tc), v ? 1 : 0);
            en_n = 1'b0; #1;
            check("R6 tc ignores en_n", int'(tc), v ? 1 : 0);
            en_n = 1'b1;
            run_cycle("R5 hold");
        end

        // R1: a mid-phase load follows preset with no clock edge.
        en_n = 1'b0; dir_down = 1'b0; load_n = 1'b0; preset = 4'd9; #1;
        check("R1 immediate load", int'(count), 9);
        preset = 4'd6; #1;
        check("R1 follows preset", int'(count), 6);
        rst_n = 1'b0;
        run_cycle("R1 load over reset");
        rst_n = 1'b1; load_n = 1'b1;
        run_cycle("R10 resume");
        run_cycle("R10 resume");
        check("R10 count after resume", int'(count), 8);

        // R9: a reset while counting.
        rst_n = 1'b0;
        run_cycle("R9 clear");
        rst_n = 1'b1;
        run_cycle("R9 after clear");
        summary();
    end

endmodule